// File: doc/BRIEF.md
# Frame Signature Accumulator

This block computes a 24-bit signature over the bytes that one colour channel sends to its DAC during the visible part of a video frame. Each visible byte arrives with a valid strobe. Consecutive visible bytes are combined into 16-bit words, and each word is folded into a feedback shift register. Bytes that arrive while blank is asserted, while the valid strobe is low, or while vertical sync is active are not counted.

The signature is reset at the start of every frame, which is the rising edge of the active-low vertical sync. When the frame ends, at the falling edge of vertical sync, the finished value is copied into a held result and a ready flag is raised. A host can then read a stable value for the whole of vertical flyback. A display pipeline uses three instances of the block, one each for red, green and blue. Byte-wise host access to the result is left to the logic around the block.

Top module: `frame_sig_accum`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `sig_ready` is 0 and `sig_out` is 0. The internal signature starts at all ones, and no half-formed pair is held.
- R2: A vsync rising edge is detected when `vsync_n` is sampled high after being sampled low. On that clock edge the signature is set to 0xFFFFFF, any held first byte of a pair is discarded, and `sig_ready` goes to 0. The byte presented in that same cycle is discarded.
- R3: A byte is accumulated only in a cycle where `pix_vld`=1, `blank_n`=1 and `vsync_n`=1, and which is not a rising-edge cycle. In every other cycle the signature and the pairing state are left unchanged.
- R4: Visible bytes are taken in pairs. The first byte of a pair becomes bits 7:0 and the second becomes bits 15:8 of a 16-bit word. That word is XORed into bits 15:0 of the signature.
- R5: After the XOR, bit 23 picks the step. If bit 23 is 0, the value is XORed with 0x610000, shifted left by one, and its bit 0 is set to 1. If bit 23 is 1, the value is shifted left by one with 0 entering bit 0. In both cases the result is clipped to 24 bits.
- R6: If a frame holds an odd number of visible bytes, the last one has no effect on the result.
- R7: A vsync falling edge is detected when `vsync_n` is sampled low after being sampled high. On that clock edge `sig_out` takes the signature accumulated so far and `sig_ready` goes to 1.
- R8: `sig_out` keeps its value until the next vsync falling edge. `sig_ready` stays at 1 until the next vsync rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | The byte on `pix_byte` is a pixel value |
| pix_byte | input | 8 | Value presented to the DAC of this channel |
| blank_n | input | 1 | Active-low blank; bytes are excluded while it is low |
| vsync_n | input | 1 | Active-low vertical sync |
| sig_out | output | 24 | Signature of the last completed frame |
| sig_ready | output | 1 | High from frame end until the next frame start |

## Verification
The bench checks that the low and high byte of each pair are not swapped, and an order error would corrupt every signature after the first word. It checks the inverted sense of the feedback step, which a design using the usual sense would miss on the first tap. It checks that blanked and non-valid bytes are ignored, and counting them would move the pairing phase and change every later word. It also drives a byte in the same cycle as the frame-start edge, ends frames on an odd trailing byte, and checks that `sig_out` holds through flyback. A design that leaked a byte across the reset, or that kept a half pair into the next frame, would produce a signature that differs from the bench's independent model.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int unsigned SIG_W_DEF  = 24;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam logic [23:0] TAP_DEF    = 24'h610000;
endpackage

// File: rtl/sig_vsync_edge.sv
module sig_vsync_edge (
  input  logic clk,
  input  logic rst,
  input  logic vsync_n,
  output logic rise,
  output logic fall,
  output logic prev
);
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= vsync_n;
  end

  assign rise = vsync_n & ~prev;
  assign fall = ~vsync_n & prev;
endmodule

// File: rtl/sig_pair_pack.sv
module sig_pair_pack #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic              half,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] low_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      half  <= 1'b0;
      low_q <= '0;
    end else if (take) begin
      half <= ~half;
      if (!half) low_q <= din;
    end
  end

  assign word_vld = take & half & ~clear;
  assign word     = {din, low_q};
endmodule

// File: rtl/sig_lfsr_reg.sv
module sig_lfsr_reg #(
  parameter int unsigned SIG_W  = 24,
  parameter int unsigned WORD_W = 16,
  parameter logic [SIG_W-1:0] TAP = 24'h610000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              step,
  input  logic [WORD_W-1:0] word,
  output logic [SIG_W-1:0]  sig
);
  logic [SIG_W-1:0] mixed;
  logic [SIG_W-1:0] nxt;

  always_comb begin
    mixed = sig ^ {{(SIG_W-WORD_W){1'b0}}, word};
    if (mixed[SIG_W-1]) nxt = {mixed[SIG_W-2:0], 1'b0};
    else begin
      mixed = mixed ^ TAP;
      nxt   = {mixed[SIG_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) sig <= '1;
    else if (step)   sig <= nxt;
  end
endmodule

// File: rtl/frame_sig_accum.sv
module frame_sig_accum #(
  parameter int unsigned SIG_W  = sig_pkg::SIG_W_DEF,
  parameter int unsigned BYTE_W = sig_pkg::BYTE_W_DEF,
  parameter logic [SIG_W-1:0] TAP = sig_pkg::TAP_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_vld,
  input  logic [BYTE_W-1:0] pix_byte,
  input  logic              blank_n,
  input  logic              vsync_n,
  output logic [SIG_W-1:0]  sig_out,
  output logic              sig_ready
);
  localparam int unsigned WORD_W = 2 * BYTE_W;

  logic              vs_rise, vs_fall, vs_prev;
  logic              take, half_w, word_vld;
  logic [WORD_W-1:0] word;
  logic [SIG_W-1:0]  crc_w;

  sig_vsync_edge u_edge (
    .clk(clk), .rst(rst), .vsync_n(vsync_n),
    .rise(vs_rise), .fall(vs_fall), .prev(vs_prev)
  );

  assign take = pix_vld & blank_n & vsync_n & ~vs_rise;

  sig_pair_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst(rst), .clear(vs_rise), .take(take), .din(pix_byte),
    .half(half_w), .word_vld(word_vld), .word(word)
  );

  sig_lfsr_reg #(.SIG_W(SIG_W), .WORD_W(WORD_W), .TAP(TAP)) u_lfsr (
    .clk(clk), .rst(rst), .init(vs_rise), .step(word_vld),
    .word(word), .sig(crc_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_out   <= '0;
      sig_ready <= 1'b0;
    end else if (vs_fall) begin
      sig_out   <= crc_w;
      sig_ready <= 1'b1;
    end else if (vs_rise) begin
      sig_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_sig_accum_chk.sv
module frame_sig_accum_chk #(
  parameter int unsigned SIG_W  = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_vld,
  input logic             blank_n,
  input logic             vsync_n,
  input logic             vs_prev,
  input logic             half_w,
  input logic [SIG_W-1:0] crc_w,
  input logic [SIG_W-1:0] sig_out,
  input logic             sig_ready
);
  assert_frame_init_R2: assert property (@(posedge clk) disable iff (rst)
    $past(vsync_n && !vs_prev) |-> (crc_w == '1 && !half_w && !sig_ready));

  assert_sync_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(vsync_n) |-> ($stable(crc_w) && $stable(half_w)));

  assert_blank_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $past(vsync_n && vs_prev && !(pix_vld && blank_n)) |-> ($stable(crc_w) && $stable(half_w)));

  assert_pair_toggle_R4: assert property (@(posedge clk) disable iff (rst)
    $past(vsync_n && vs_prev && pix_vld && blank_n) |-> (half_w != $past(half_w)));

  assert_ready_src_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_ready) |-> ($past(!vsync_n && vs_prev) && sig_out == $past(crc_w)));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (sig_ready && $past(sig_ready)) |-> $stable(sig_out));
endmodule

bind frame_sig_accum frame_sig_accum_chk #(.SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst(rst), .pix_vld(pix_vld), .blank_n(blank_n),
  .vsync_n(vsync_n), .vs_prev(vs_prev), .half_w(half_w), .crc_w(crc_w),
  .sig_out(sig_out), .sig_ready(sig_ready)
);

// File: tb/frame_sig_accum_tb.sv
module frame_sig_accum_tb;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_vld = 1'b0;
  logic [7:0]  pix_byte = '0;
  logic        blank_n = 1'b0;
  logic        vsync_n = 1'b0;
  logic [23:0] sig_out;
  logic        sig_ready;

  int checks = 0;
  int errors = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  bq[$];
  bit          kq[$];
  bit          vq[$];

  always #(CLK_P/2) clk = ~clk;

  frame_sig_accum u_dut (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_byte(pix_byte),
    .blank_n(blank_n), .vsync_n(vsync_n), .sig_out(sig_out), .sig_ready(sig_ready)
  );

  function automatic logic [23:0] model_step(logic [23:0] c, logic [15:0] w);
    logic [23:0] x;
    x = c ^ {8'h00, w};
    if (x[23] == 1'b0) begin
      x = x ^ 24'h610000;
      x = (x << 1) | 24'h1;
    end else x = x << 1;
    return x & 24'hFFFFFF;
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: computes the expected signature, pushes it, then plays the frame.
  task automatic play_frame(string tag);
    logic [23:0] acc = 24'hFFFFFF;
    logic [7:0]  lo = '0;
    bit          have = 0;
    foreach (bq[i]) begin
      if (vq[i] && kq[i]) begin
        if (!have) begin lo = bq[i]; have = 1; end
        else begin acc = model_step(acc, {bq[i], lo}); have = 0; end
      end
    end
    exp_q.push_back(acc);
    tag_q.push_back(tag);
    @(negedge clk);
    vsync_n = 1'b1; pix_vld = 1'b1; blank_n = 1'b1; pix_byte = 8'h5A; // R2: discarded byte
    @(negedge clk);
    chk("R2 ready low after frame start", {23'h0, sig_ready}, 24'h0);
    foreach (bq[i]) begin
      pix_byte = bq[i]; pix_vld = vq[i]; blank_n = kq[i];
      @(negedge clk);
    end
    pix_vld = 1'b0; blank_n = 1'b0; vsync_n = 1'b0;
    repeat (8) @(negedge clk);
    bq.delete(); kq.delete(); vq.delete();
  endtask

  task automatic add(logic [7:0] b, bit k, bit v);
    bq.push_back(b); kq.push_back(k); vq.push_back(v);
  endtask

  // Monitor: pops expected signatures on ready and checks the hold in flyback.
  logic        rdy_prev = 1'b0;
  logic [23:0] held = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sig_ready && !rdy_prev) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7: ready with no expected frame, actual=%h expected=none", sig_out);
        end else begin
          string t;
          logic [23:0] e;
          t = tag_q.pop_front();
          e = exp_q.pop_front();
          chk({"R7 ", t}, sig_out, e);
        end
      end else if (sig_ready && rdy_prev) begin
        chk("R8 hold in flyback", sig_out, held);
      end
      rdy_prev = sig_ready;
      held = sig_out;
    end
  end

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", {23'h0, sig_ready}, 24'h0);
    chk("R1 out after reset", sig_out, 24'h0);

    // R2/R7: empty frame gives all ones
    play_frame("empty frame");
    // R4/R5: single zero pair gives 0xFFFFFE
    add(8'h00, 1, 1); add(8'h00, 1, 1);
    play_frame("R4 zero pair");
    // R6: trailing odd byte dropped, result still 0xFFFFFE
    add(8'h00, 1, 1); add(8'h00, 1, 1); add(8'hC3, 1, 1);
    play_frame("R6 odd trailing byte");
    // R3: blanked and non-valid bytes between a pair are ignored
    add(8'h00, 1, 1); add(8'h77, 0, 1); add(8'h99, 1, 0); add(8'h00, 1, 1);
    play_frame("R3 ignored bytes");
    // R4: byte order matters; 0x12 low, 0x34 high
    add(8'h12, 1, 1); add(8'h34, 1, 1); add(8'h56, 1, 1); add(8'h78, 1, 1);
    play_frame("R4 ordered pairs");
    // R5: random frames with random blanking exercise both step branches
    for (int f = 0; f < 8; f++) begin
      int n = 150 + int'($urandom_range(0, 101));
      for (int i = 0; i < n; i++)
        add(8'($urandom), ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) != 0));
      play_frame("R5 random frame");
    end

    repeat (4) @(negedge clk);
    chk("R7 all frames reported", 24'(exp_q.size()), 24'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule